// File: doc/BRIEF.md
# Per-Pad Output Source Crossbar for GPIO Pads

This block drives 64 I/O pads. Every pad owns two select registers: one picks the source of the pad's output level, the other picks the source of its output enable. Two codes stand for fixed logic levels. With these, software runs a pad as a plain GPIO: it writes the level it wants into the data select and the direction it wants into the enable select. The other codes in range connect the pad to one line of a 62-bit bus of peripheral outputs. Because of this, one register serves both for assigning a pin function and for software I/O.

The top bit of each select register inverts the chosen signal before it reaches the pad. The pads' input levels pass through a two-stage synchroniser and can be read as two packed 32-bit words. The register port is a simple single-cycle bus: address, write enable, write data, and read data that is registered one cycle after the address.

Top module: `pad_xbar_top`

## Requirements
- R1: After a synchronous reset, every select register reads 0, `pad_out` and `pad_oe` are all 0, and `bus_rd_data` is 0.
- R2: Pad n's data select sits at byte offset 0x50 + 8n and its enable select at 0x54 + 8n. A write to either one is stored in full and read back unchanged, and it leaves the neighbouring register untouched.
- R3: In bits 30:0 of a select register, code 0 drives a constant 0 and code 1 drives a constant 1 onto the pad's data or enable.
- R4: Code k, for k from 2 to 63, drives peripheral line `periph_out[k-2]` onto the pad.
- R5: Any code of 64 or more in bits 30:0 drives 0 before inversion.
- R6: When bit 31 of a select register is set, the routed value is inverted before it reaches the pad.
- R7: Pad inputs pass through two synchronising flops. Pads 31..0 read as bits 31..0 at offset 0x48, and pads 63..32 read as bits 31..0 at offset 0x4C.
- R8: Writes to 0x48, 0x4C, unmapped offsets or offsets that are not word aligned change no register and no pad output. Reads from unmapped or misaligned offsets return 0.
- R9: `bus_rd_data` shows the contents of the address sampled at the previous clock edge.
- R10: `pad_out` and `pad_oe` are registered. A change in a select register or in a peripheral line reaches the pads one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe for the current cycle |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Registered read data |
| periph_out | input | 62 | Output lines from the peripherals that can be routed |
| pad_in | input | 64 | Asynchronous pad input levels |
| pad_out | output | 64 | Output level for each pad |
| pad_oe | output | 64 | Output enable for each pad |

## Verification
The routing is tested with both constant codes, with the lowest and highest peripheral codes while a one-hot peripheral pattern moves between the two end lines, and with codes past the last peripheral both with and without inversion. Together these separate an off-by-one in the peripheral index from a missing range check or a dropped invert. Input readback uses an asymmetric 64-bit pattern that exposes swapped words or a missing synchroniser stage, and a read issued straight after an input change shows whether both stages are present. Address decoding is tested with writes to the read-only words, to a misaligned offset and to an offset past the map, and the register next to each target is read back.

// File: rtl/pad_xbar_pkg.sv
package pad_xbar_pkg;

  localparam logic [31:0] IN_LO_OFF  = 32'h48;
  localparam logic [31:0] IN_HI_OFF  = 32'h4C;
  localparam logic [31:0] SEL_BASE   = 32'h50;
  localparam int unsigned SEL_STRIDE = 8;
  localparam int          INV_BIT    = 31;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_IN_LO,
    ACC_IN_HI,
    ACC_DOUT,
    ACC_DOEN
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [7:0] pad;
  } acc_t;

  // Map a byte address onto a register kind and a pad index
  function automatic acc_t decode_addr(input logic [31:0] a, input int unsigned num_pads);
    acc_t        r;
    logic [31:0] rel;
    r.kind = ACC_NONE;
    r.pad  = '0;
    rel    = a - SEL_BASE;
    if (a[1:0] == 2'b00) begin
      if (a == IN_LO_OFF) begin
        r.kind = ACC_IN_LO;
      end else if (a == IN_HI_OFF && num_pads > 32) begin
        r.kind = ACC_IN_HI;
      end else if (a >= SEL_BASE && rel < num_pads * SEL_STRIDE) begin
        r.pad  = rel[10:3];
        r.kind = rel[2] ? ACC_DOEN : ACC_DOUT;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/pad_in_sync.sv
module pad_in_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end

endmodule

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
  import pad_xbar_pkg::*;
#(
  parameter int NUM_PADS = 64,
  parameter int ADDR_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr_en,
  input  logic [31:0]                bus_wr_data,
  output logic [31:0]                bus_rd_data,
  input  logic [NUM_PADS-1:0]        pad_sync,
  output logic [NUM_PADS-1:0][31:0]  dout_sel,
  output logic [NUM_PADS-1:0][31:0]  doen_sel
);

  localparam int PAD_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  acc_t             acc;
  logic [PAD_W-1:0] idx;
  logic [63:0]      in_ext;
  logic [31:0]      rd_next;

  always_comb begin
    acc = decode_addr(32'(bus_addr), NUM_PADS);
    idx = acc.pad[PAD_W-1:0];
    in_ext = '0;
    in_ext[NUM_PADS-1:0] = pad_sync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_sel <= '0;
      doen_sel <= '0;
    end else if (bus_wr_en) begin
      if (acc.kind == ACC_DOUT) dout_sel[idx] <= bus_wr_data;
      if (acc.kind == ACC_DOEN) doen_sel[idx] <= bus_wr_data;
    end
  end

  always_comb begin
    case (acc.kind)
      ACC_IN_LO: rd_next = in_ext[31:0];
      ACC_IN_HI: rd_next = in_ext[63:32];
      ACC_DOUT:  rd_next = dout_sel[idx];
      ACC_DOEN:  rd_next = doen_sel[idx];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rd_data <= '0;
    else     bus_rd_data <= rd_next;
  end

  AST_SEL_WRITE_STORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && acc.kind == ACC_DOUT) |=> dout_sel[$past(idx)] == $past(bus_wr_data)); // R2

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc.kind == ACC_NONE) |=> bus_rd_data == 32'd0); // R8

  AST_INPUT_WORD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && (acc.kind == ACC_IN_LO || acc.kind == ACC_IN_HI))
      |=> ($stable(dout_sel) && $stable(doen_sel))); // R8

endmodule

// File: rtl/pad_route.sv
module pad_route #(
  parameter int NUM_PERIPH = 62
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [31:0]           sel_d,
  input  logic [31:0]           sel_e,
  input  logic [NUM_PERIPH-1:0] periph,
  output logic                  out_q,
  output logic                  oe_q
);

  localparam int FIRST_CODE = 2;
  localparam int LAST_CODE  = NUM_PERIPH + FIRST_CODE - 1;
  localparam int PIW        = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

  function automatic logic route_bit(input logic [31:0] sel, input logic [NUM_PERIPH-1:0] per);
    logic [30:0]    code;
    logic [PIW-1:0] pidx;
    logic           v;
    code = sel[30:0];
    pidx = PIW'(code - 31'(FIRST_CODE));
    if (code == 31'd0)                   v = 1'b0;
    else if (code == 31'd1)              v = 1'b1;
    else if (code <= 31'(LAST_CODE))     v = per[pidx];
    else                                 v = 1'b0;
    return v ^ sel[31];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= route_bit(sel_d, periph);
      oe_q  <= route_bit(sel_e, periph);
    end
  end

  logic [PIW-1:0] d_idx;
  assign d_idx = PIW'(sel_d[30:0] - 31'(FIRST_CODE));

  AST_CONST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel_d == 32'd0) |=> !out_q); // R3

  AST_CONST_ONE: assert property (@(posedge clk) disable iff (rst)
    (sel_e == 32'd1) |=> oe_q); // R3

  AST_PERIPH_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (sel_d[30:0] >= 31'(FIRST_CODE) && sel_d[30:0] <= 31'(LAST_CODE))
      |=> out_q == $past(periph[d_idx] ^ sel_d[31])); // R4

  AST_HIGH_CODE: assert property (@(posedge clk) disable iff (rst)
    (sel_e[30:0] > 31'(LAST_CODE)) |=> oe_q == $past(sel_e[31])); // R5

  AST_INVERT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel_d == 32'h8000_0000) |=> out_q); // R6

endmodule

// File: rtl/pad_xbar_top.sv
module pad_xbar_top
  import pad_xbar_pkg::*;
#(
  parameter int NUM_PADS   = 64,
  parameter int NUM_PERIPH = 62,
  parameter int ADDR_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr_en,
  input  logic [31:0]           bus_wr_data,
  output logic [31:0]           bus_rd_data,
  input  logic [NUM_PERIPH-1:0] periph_out,
  input  logic [NUM_PADS-1:0]   pad_in,
  output logic [NUM_PADS-1:0]   pad_out,
  output logic [NUM_PADS-1:0]   pad_oe
);

  logic [NUM_PADS-1:0]       pad_sync;
  logic [NUM_PADS-1:0][31:0] dout_sel;
  logic [NUM_PADS-1:0][31:0] doen_sel;

  pad_in_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pad_in),
    .d_sync  (pad_sync)
  );

  pad_cfg_regs #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_data (bus_rd_data),
    .pad_sync    (pad_sync),
    .dout_sel    (dout_sel),
    .doen_sel    (doen_sel)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    pad_route #(.NUM_PERIPH(NUM_PERIPH)) u_route (
      .clk    (clk),
      .rst    (rst),
      .sel_d  (dout_sel[p]),
      .sel_e  (doen_sel[p]),
      .periph (periph_out),
      .out_q  (pad_out[p]),
      .oe_q   (pad_oe[p])
    );
  end

endmodule

// File: tb/sim_pad_xbar_top.sv
module sim_pad_xbar_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic [31:0] bus_rd_data;
  logic [61:0] periph_out = '0;
  logic [63:0] pad_in = '0;
  logic [63:0] pad_out;
  logic [63:0] pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pad_xbar_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
    .periph_out(periph_out), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_en = 1'b1; bus_wr_data = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rd_data;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic logic [11:0] dout_a(input int n); return 12'(32'h50 + 8 * n); endfunction
  function automatic logic [11:0] doen_a(input int n); return 12'(32'h54 + 8 * n); endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pad_out after reset", pad_out, 64'd0);
    chk("R1 pad_oe after reset", pad_oe, 64'd0);
    chk("R1 rd_data after reset", 64'(bus_rd_data), 64'd0);
    rd(dout_a(0), d);  chk("R1 pad0 data select", 64'(d), 64'd0);
    rd(doen_a(63), d); chk("R1 pad63 enable select", 64'(d), 64'd0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(dout_a(0), 32'h8000_0005);
    wr(doen_a(63), 32'h0000_0021);
    rd(dout_a(0), d);  chk("R2 pad0 data select readback", 64'(d), 64'h8000_0005);
    rd(doen_a(0), d);  chk("R2 pad0 enable untouched", 64'(d), 64'd0);
    rd(doen_a(63), d); chk("R2 pad63 enable readback", 64'(d), 64'h21);
    rd(dout_a(63), d); chk("R2 pad63 data untouched", 64'(d), 64'd0);
    wr(dout_a(0), 32'd0);
    wr(doen_a(63), 32'd0);
  endtask

  task automatic t_const();
    wr(dout_a(5), 32'd1);
    wr(doen_a(5), 32'd1);
    settle();
    chk("R3 pad5 out const one", 64'(pad_out[5]), 64'd1);
    chk("R3 pad5 oe const one", 64'(pad_oe[5]), 64'd1);
    chk("R3 other pads oe low", pad_oe & ~(64'd1 << 5), 64'd0);
    wr(dout_a(5), 32'd0);
    settle();
    chk("R3 pad5 out const zero", 64'(pad_out[5]), 64'd0);
  endtask

  task automatic t_periph();
    wr(dout_a(7), 32'd2);
    wr(dout_a(8), 32'd63);
    @(negedge clk);
    periph_out = 62'h1;
    #1;
    chk("R10 pad7 before edge", 64'(pad_out[7]), 64'd0);
    settle();
    chk("R4 code 2 selects line 0", 64'(pad_out[7]), 64'd1);
    chk("R4 code 63 ignores line 0", 64'(pad_out[8]), 64'd0);
    periph_out = 62'h2000_0000_0000_0000;
    settle();
    chk("R4 code 2 follows line 0 low", 64'(pad_out[7]), 64'd0);
    chk("R4 code 63 selects line 61", 64'(pad_out[8]), 64'd1);
    chk("R10 routed pads oe stay low", 64'(pad_oe[8:7]), 64'd0);
  endtask

  task automatic t_high();
    periph_out = '1;
    wr(dout_a(9), 32'd64);
    settle();
    chk("R5 code 64 drives zero", 64'(pad_out[9]), 64'd0);
    wr(dout_a(9), 32'h7FFF_FFFF);
    settle();
    chk("R5 max code drives zero", 64'(pad_out[9]), 64'd0);
    wr(dout_a(9), 32'h8000_0040);
    settle();
    chk("R6 code 64 inverted is one", 64'(pad_out[9]), 64'd1);
  endtask

  task automatic t_invert();
    wr(doen_a(10), 32'h8000_0000);
    wr(dout_a(10), 32'h8000_0002);
    settle();
    chk("R6 inverted const zero enables", 64'(pad_oe[10]), 64'd1);
    chk("R6 inverted line 0 high", 64'(pad_out[10]), 64'd0);
    @(negedge clk);
    periph_out = '0;
    settle();
    chk("R6 inverted line 0 low", 64'(pad_out[10]), 64'd1);
  endtask

  task automatic t_input();
    logic [31:0] d;
    pad_in = 64'hA5A5_0F0F_1234_8001;
    repeat (3) settle();
    rd(12'h48, d); chk("R7 low word", 64'(d), 64'h1234_8001);
    rd(12'h4C, d); chk("R7 high word", 64'(d), 64'hA5A5_0F0F);
    @(negedge clk);
    pad_in = ~64'hA5A5_0F0F_1234_8001;
    rd(12'h4C, d); chk("R7 two-stage delay", 64'(d), 64'hA5A5_0F0F);
    rd(12'h4C, d); chk("R7 new high word", 64'(d), 64'h5A5A_F0F0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    logic [63:0] out_before, oe_before;
    settle();
    out_before = pad_out; oe_before = pad_oe;
    wr(12'h48, 32'hFFFF_FFFF);
    wr(12'h4C, 32'h0000_0001);
    wr(12'h051, 32'h0000_0001);
    wr(12'h250, 32'h0000_0001);
    settle();
    chk("R8 pad_out unchanged", pad_out, out_before);
    chk("R8 pad_oe unchanged", pad_oe, oe_before);
    rd(12'h48, d);  chk("R8 input word not written", 64'(d), 64'hEDCB_7FFE);
    rd(dout_a(0), d); chk("R8 misaligned write ignored", 64'(d), 64'd0);
    rd(doen_a(63), d); chk("R8 past-map write ignored", 64'(d), 64'd0);
    rd(12'h044, d); chk("R8 unmapped read zero", 64'(d), 64'd0);
    rd(12'h250, d); chk("R8 past-map read zero", 64'(d), 64'd0);
    rd(12'h051, d); chk("R8 misaligned read zero", 64'(d), 64'd0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    rd(doen_a(10), d); chk("R9 first read", 64'(d), 64'h8000_0000);
    @(negedge clk);
    bus_addr = dout_a(9);
    #1;
    chk("R9 data still from old address", 64'(bus_rd_data), 64'h8000_0000);
    @(negedge clk);
    chk("R9 data from new address", 64'(bus_rd_data), 64'h8000_0040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_map();
    t_const();
    t_periph();
    t_high();
    t_invert();
    t_input();
    t_ignored();
    t_latency();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule